// File: doc/BRIEF.md
# Subcycle-Dithered PWM Generator

This block is one pulse-width modulation channel that runs directly on the system clock. An 8-bit duty word sets the average high fraction of the output over a frame of 256 clocks, and that average is exactly duty/256. Rather than emit one long pulse per frame, the block cuts the frame into shorter subcycles to raise the ripple frequency seen by the load. In half split it uses two subcycles of 128 clocks. In quarter split it uses four subcycles of 64 clocks.

The upper bits of the duty word set the high time shared by every subcycle. The low bits that remain add one extra high clock to some of the subcycles, so that the frame total still equals the full 8-bit value. Duty and split are copied into shadow registers only at frame boundaries, so the pattern never changes partway through a frame. Dropping the enable forces the output low and parks the frame counter at zero.

Top module: `spwm_gen`

## Requirements
- R1: Over any complete 256-clock frame, the output is high for exactly `duty` clocks, in both split settings.
- R2: With `split_i` = 0 (half split), the frame holds two 128-clock subcycles. The first subcycle is high for `duty[7:1] + duty[0]` clocks and the second for `duty[7:1]` clocks.
- R3: With `split_i` = 1 (quarter split), the frame holds four 64-clock subcycles. Subcycle i (0..3) is high for `duty[7:2]` clocks, plus one more clock when i < `duty[1:0]`.
- R4: Inside each subcycle, the high clocks form one contiguous run that starts on the subcycle's first clock. A duty of 0 keeps the output low for the whole frame.
- R5: A change to `duty_i` or `split_i` made partway through a frame leaves the current frame unaltered and takes effect from the start of the next frame.
- R6: From the first clock after `enable_i` is sampled low, the output stays low and the frame counter stays at zero.
- R7: Once `enable_i` is sampled high after being low, the next 256 clocks form a complete frame that begins at subcycle 0 and uses the duty and split values present at that clock edge.
- R8: While `rst_ni` is low, the output is low whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the counter steps once per clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel on/off control |
| split_i | input | 1 | 0 = two 128-clock subcycles, 1 = four 64-clock subcycles |
| duty_i | input | 8 | Duty word; the frame average is duty/256 |
| pwm_o | output | 1 | PWM output level |

## Verification
The hardest case to reach is a duty or split change that arrives mid-frame. The port alone shows nothing unless the next frame uses a different value in a different split. The bench therefore starts a frame with one value in half split and rewrites both inputs a few clocks in. It checks that the subcycle counts of that frame still match the old setting and that the following frame matches the new one exactly. To prove the counter is cleared on disable, the bench re-enables with a duty of 1, whose single high clock shows up only if the new frame truly begins at position zero.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned PWM_W = 8;

  typedef logic [PWM_W-1:0] pwm_word_t;

  typedef enum logic {
    SPLIT_HALF    = 1'b0,
    SPLIT_QUARTER = 1'b1
  } split_e;

  localparam pwm_word_t FRAME_LAST = '1;
  localparam pwm_word_t HALF_MASK  = pwm_word_t'((1 << (PWM_W - 1)) - 1);
  localparam pwm_word_t QUART_MASK = pwm_word_t'((1 << (PWM_W - 2)) - 1);

  // Position of the frame count inside its current subcycle.
  function automatic pwm_word_t sub_pos(pwm_word_t cnt, split_e mode);
    return cnt & ((mode == SPLIT_QUARTER) ? QUART_MASK : HALF_MASK);
  endfunction

  // Index of the current subcycle (0..1 in half split, 0..3 in quarter split).
  function automatic logic [1:0] sub_idx(pwm_word_t cnt, split_e mode);
    if (mode == SPLIT_QUARTER) return cnt[PWM_W-1 -: 2];
    return {1'b0, cnt[PWM_W-1]};
  endfunction

  // High length of the current subcycle: the shared base plus the dithered extra clock.
  function automatic pwm_word_t sub_len(pwm_word_t duty, pwm_word_t cnt, split_e mode);
    logic [1:0] idx;
    logic       extra;
    pwm_word_t  base;
    idx = sub_idx(cnt, mode);
    if (mode == SPLIT_QUARTER) begin
      base  = duty >> 2;
      extra = (idx < duty[1:0]);
    end else begin
      base  = duty >> 1;
      extra = (idx == 2'd0) && duty[0];
    end
    return base + pwm_word_t'(extra);
  endfunction
endpackage

// File: rtl/spwm_cycle_ctr.sv
module spwm_cycle_ctr
  import spwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  output logic      run_o,
  output pwm_word_t cnt_o,
  output logic      wrap_o
);
  logic run_q;
  pwm_word_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= enable_i;
      if (!enable_i || !run_q) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign wrap_o = run_q && (cnt_q == FRAME_LAST);

  // R6: disabling parks the counter at zero
  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (cnt_o == '0 && !run_o));
  // R1: the last clock of a frame is followed by a fresh frame
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && enable_i) |=> (cnt_o == '0 && run_o));
  // R2: one step per clock inside a frame
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && enable_i && !wrap_o) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/spwm_shadow.sv
module spwm_shadow
  import spwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  pwm_word_t duty_i,
  input  split_e    mode_i,
  output pwm_word_t duty_o,
  output split_e    mode_o
);
  pwm_word_t duty_q;
  split_e    mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      mode_q <= SPLIT_HALF;
    end else if (load_i) begin
      duty_q <= duty_i;
      mode_q <= mode_i;
    end
  end

  assign duty_o = duty_q;
  assign mode_o = mode_q;

  // R5: no reload anywhere except at a frame boundary
  p_hold_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(duty_o) && $stable(mode_o)));
endmodule

// File: rtl/spwm_shaper.sv
module spwm_shaper
  import spwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  pwm_word_t cnt_i,
  input  pwm_word_t duty_i,
  input  split_e    mode_i,
  output logic      pwm_o
);
  pwm_word_t pos_w;
  pwm_word_t len_w;

  always_comb begin
    pos_w = sub_pos(cnt_i, mode_i);
    len_w = sub_len(duty_i, cnt_i, mode_i);
    pwm_o = run_i && (pos_w < len_w);
  end

  // R4: a subcycle with any high time opens high
  p_start_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pos_w == '0 && len_w != '0) |-> pwm_o);
  // R4: zero duty never drives high
  p_zero_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |-> !pwm_o);
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
  import spwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             split_i,
  input  logic [PWM_W-1:0] duty_i,
  output logic             pwm_o
);
  logic      run_w;
  logic      wrap_w;
  logic      load_w;
  pwm_word_t cnt_w;
  pwm_word_t duty_sh_w;
  split_e    mode_sh_w;

  spwm_cycle_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .run_o    (run_w),
    .cnt_o    (cnt_w),
    .wrap_o   (wrap_w)
  );

  assign load_w = !run_w || wrap_w;

  spwm_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .duty_i (duty_i),
    .mode_i (split_e'(split_i)),
    .duty_o (duty_sh_w),
    .mode_o (mode_sh_w)
  );

  spwm_shaper u_shaper (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .cnt_i  (cnt_w),
    .duty_i (duty_sh_w),
    .mode_i (mode_sh_w),
    .pwm_o  (pwm_o)
  );

  // R6: output low from the clock after enable is seen low
  p_off_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !pwm_o);
  // R8: reset forces the output low
  always_comb begin
    if (!rst_ni) p_reset_low_r8: assert (!pwm_o);
  end
endmodule

// File: tb/spwm_gen_bench.sv
module spwm_gen_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       pwm;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  spwm_gen u_spwm_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .enable_i (en),
    .split_i  (mode),
    .duty_i   (duty),
    .pwm_o    (pwm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sub(int d, bit m, int i);
    if (!m) return (i == 0) ? (d + 1) / 2 : d / 2;
    return (d + 3 - i) / 4;
  endfunction

  task automatic restart(input int d, input bit m);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    duty = d[7:0];
    mode = m;
    en   = 1'b1;
    @(posedge clk);
  endtask

  // Samples one full frame; optionally rewrites inputs after sample chg_at.
  task automatic measure(input int d, input bit m, input int chg_at, input int nd, input bit nm);
    int  hi[4];
    bit  seen_low[4];
    bit  bad[4];
    int  tot;
    int  sl;
    int  ns;
    sl  = m ? 64 : 128;
    ns  = m ? 4 : 2;
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      hi[i] = 0; seen_low[i] = 1'b0; bad[i] = 1'b0;
    end
    for (int k = 0; k < 256; k++) begin
      int s;
      @(negedge clk);
      s = k / sl;
      if (pwm) begin
        hi[s]++;
        tot++;
        if (seen_low[s]) bad[s] = 1'b1;
      end else begin
        seen_low[s] = 1'b1;
        if ((k % sl) == 0 && exp_sub(d, m, s) > 0) bad[s] = 1'b1;
      end
      if (k == chg_at) begin
        duty = nd[7:0];
        mode = nm;
      end
    end
    for (int i = 0; i < ns; i++) begin
      chk(hi[i] == exp_sub(d, m, i), m ? "R3 quarter subcycle count" : "R2 half subcycle count",
          hi[i], exp_sub(d, m, i));
      chk(!bad[i], "R4 contiguous run from subcycle start", int'(bad[i]), 0);
    end
    chk(tot == d, "R1 frame total", tot, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hits;
    en = 1'b1;
    duty = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      chk(pwm == 1'b0, "R8 output low in reset", int'(pwm), 0);
    end
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 R3 R4: exhaustive sweep, both splits
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 256; d++) begin
        restart(d, m[0]);
        measure(d, m[0], -1, 0, 1'b0);
      end
    end

    // R5: mid-frame rewrite of duty and split
    restart(100, 1'b0);
    measure(100, 1'b0, 10, 201, 1'b1);
    measure(201, 1'b1, -1, 0, 1'b0);
    restart(7, 1'b1);
    measure(7, 1'b1, 200, 250, 1'b0);
    measure(250, 1'b0, -1, 0, 1'b0);

    // R6: disable mid-frame with full duty
    restart(255, 1'b0);
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    hits = 0;
    repeat (300) begin
      @(negedge clk);
      if (pwm) hits++;
    end
    chk(hits == 0, "R6 output low while disabled", hits, 0);

    // R7: re-enable starts at subcycle 0 with values present at the enabling edge
    duty = 8'd1;
    mode = 1'b0;
    en   = 1'b1;
    @(posedge clk);
    measure(1, 1'b0, -1, 0, 1'b0);
    restart(255, 1'b1);
    repeat (77) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    duty = 8'd3;
    mode = 1'b1;
    en   = 1'b1;
    @(posedge clk);
    measure(3, 1'b1, -1, 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule